// File: doc/BRIEF.md
# Unified Shift and Rotate Funnel Unit

This block performs every shift and rotate kind of a general-purpose integer datapath with one shared piece of hardware. A request carries a 32-bit operand, a second operand used only by the double-precision shifts, an incoming carry bit, a 3-bit operation code, an 8-bit count and a width selector (8, 16 or 32 bits). The unit turns each request into a single right shift of an operation-specific 64-bit funnel word. Left-going operations place the operand in the upper half and shift right by the two's complement of the count. Rotates at narrow widths repeat the operand across the whole funnel word. Rotate-through-carry embeds the carry bit next to a copy of the operand.

The right shift is split into a coarse stage that moves by multiples of four and a fine stage that moves by 0 to 3. The funnel word carries one extra guard bit below bit 0, so the bit shifted out last comes out of the same shift. For right-going kinds this is the guard bit. For left-going kinds it is the output bit just above the width. Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one output register. A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A held result stays unchanged while `out_valid` is high and `out_ready` is low.

Top module: `shf_unit`

## Requirements
- R1: Operation codes are 000 rotate-left, 001 rotate-right, 010 rotate-left-through-carry, 011 rotate-right-through-carry, 100 shift-left, 101 logical shift-right, 111 arithmetic shift-right. Logical shifts fill vacated positions with zeros.
- R2: Arithmetic shift-right (111) fills vacated positions with the operand's sign bit at the selected width, also for counts at or above the width, and then the carry equals the sign bit.
- R3: Rotate-left and rotate-right rotate the operand within the selected width by the count modulo the width, for any count 1 to 31.
- R4: Rotate-through-carry rotates the (width+1)-bit value formed by the carry bit above the operand, for counts 1 to the width. Counts above the width are reduced before the request reaches the unit.
- R5: For a nonzero count the carry output is the last bit shifted out: operand bit count-1 for right shifts, operand bit width-count for left shifts (zero once the count exceeds the width for the logical shifts), result bit 0 for rotate-left, and result bit width-1 for rotate-right.
- R6: A count of zero after masking returns the operand (masked to the width) and passes the carry input to the carry output unchanged.
- R7: Width code 00 selects 8 bits, 01 selects 16 bits, 10 and 11 select 32 bits. Operand bits above the width are ignored, and result bits above the width are zero.
- R8: Only the low 5 bits of `in_count` are used, and bits 7:5 have no effect.
- R9: When `in_dbl` is 1 with code 101, vacated upper positions fill from the low bits of the second operand. With code 100, vacated lower positions fill from the top bits of the second operand at the selected width. `in_dbl` has no effect on any other code.
- R10: Code 110 behaves as shift-left (100), without the double-precision fill.
- R11: A logical shift by a count above the width returns zero.
- R12: Each accepted request yields its result one cycle later. `in_ready` is low only while a result is held with `out_ready` low, and a held result stays stable until taken.
- R13: During and after reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 3 | Operation code |
| in_width | input | 2 | Width selector |
| in_dbl | input | 1 | Double-precision fill enable |
| in_carry | input | 1 | Incoming carry bit |
| in_count | input | 8 | Shift count (low 5 bits used) |
| in_opnd_a | input | 32 | Operand to shift |
| in_opnd_b | input | 32 | Fill source for double-precision shifts |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Shift result, zero above the width |
| out_carry | output | 1 | Last bit shifted out |

## Verification
The hardest cases to reach are the carry bit at counts that equal or pass the width at the narrow widths. There the carry comes from funnel bits that lie between the repeated copies, the embedded carry and the zero fill. The stimulus therefore walks every code, every width, both fill settings and every count from 0 to 31 against an independent bit-serial model. Bits 7:5 of the count change along the way. A second hard case is the stream cycle in which a held result is released while a new request waits. The bench builds that cycle directly, with back-pressure held for several cycles first.

// File: rtl/shf_pkg.sv
package shf_pkg;
  parameter int DATA_W  = 32;
  localparam int FUN_W  = 2 * DATA_W;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int OUT_W  = DATA_W + 2;   // result, one bit above, guard below
  localparam int WV_W   = CNT_W + 2;

  typedef enum logic [2:0] {
    OP_ROL  = 3'b000,
    OP_ROR  = 3'b001,
    OP_RCL  = 3'b010,
    OP_RCR  = 3'b011,
    OP_SHL  = 3'b100,
    OP_SHR  = 3'b101,
    OP_SHLA = 3'b110,
    OP_SAR  = 3'b111
  } shf_op_e;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_32B = 2'd3
  } shf_wid_e;
endpackage

// File: rtl/shf_funnel_build.sv
module shf_funnel_build
  import shf_pkg::*;
(
  input  shf_op_e             op,
  input  logic [1:0]          wsel,
  input  logic                dbl,
  input  logic                cf,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [FUN_W-1:0]    funnel,
  output logic [CNT_W-1:0]    amt,
  output logic                left,
  output logic [WV_W-1:0]     wval,
  output logic [DATA_W-1:0]   wmask
);
  logic [DATA_W-1:0] x, y, sx;
  logic [FUN_W-1:0]  x64, y64, rep, cf64;
  logic              sgn;

  always_comb begin
    unique case (wsel)
      WID_8:   wval = WV_W'(8);
      WID_16:  wval = WV_W'(16);
      default: wval = WV_W'(DATA_W);
    endcase
    wmask = DATA_W'((FUN_W'(1) << wval) - FUN_W'(1));
    x     = a & wmask;
    y     = b & wmask;
    sgn   = x[wval - WV_W'(1)];
    sx    = sgn ? (x | ~wmask) : x;
    x64   = FUN_W'(x);
    y64   = FUN_W'(y);
    cf64  = FUN_W'(cf);
    unique case (wsel)
      WID_8:   rep = {(FUN_W/8){x[7:0]}};
      WID_16:  rep = {(FUN_W/16){x[15:0]}};
      default: rep = {2{x}};
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ROL, OP_ROR: funnel = rep;
      OP_RCL: funnel = (x64 << DATA_W) | (cf64 << (DATA_W - 1))
                     | ((x64 << (DATA_W - 1)) >> wval);
      OP_RCR: funnel = (x64 << (wval + WV_W'(1))) | (cf64 << wval) | x64;
      OP_SHL: funnel = dbl ? ((x64 << DATA_W) | ((y64 << DATA_W) >> wval))
                           : (x64 << DATA_W);
      OP_SHLA: funnel = x64 << DATA_W;
      OP_SHR: funnel = dbl ? ((y64 << wval) | x64) : x64;
      default: funnel = {{DATA_W{sgn}}, sx};
    endcase
    left = (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SHLA);
    amt  = left ? (CNT_W'(0) - cnt) : cnt;
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int IN_W  = 65,
  parameter int OUT_W = 37,
  parameter int STEP  = 4,
  parameter int SEL_W = 3
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] dout
);
  localparam int NCAND = 2 ** SEL_W;
  logic [OUT_W-1:0] cand [NCAND];

  generate
    for (genvar i = 0; i < NCAND; i++) begin : g_cand
      assign cand[i] = din[i*STEP +: OUT_W];
    end
  endgenerate

  assign dout = cand[sel];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_op,
  input  logic [1:0]  in_width,
  input  logic        in_dbl,
  input  logic        in_carry,
  input  logic [7:0]  in_count,
  input  logic [31:0] in_opnd_a,
  input  logic [31:0] in_opnd_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_result,
  output logic        out_carry
);
  localparam int FINE_SEL = 2;
  localparam int CRS_SEL  = CNT_W - FINE_SEL;
  localparam int CRS_OUT  = OUT_W + (2 ** FINE_SEL) - 1;

  shf_op_e            op;
  logic [CNT_W-1:0]   cnt;
  logic [FUN_W-1:0]   funnel;
  logic [CNT_W-1:0]   amt;
  logic               left;
  logic [WV_W-1:0]    wval;
  logic [DATA_W-1:0]  wmask;
  logic [CRS_OUT-1:0] crs;
  logic [OUT_W-1:0]   fine;
  logic [DATA_W-1:0]  res_next;
  logic               car_next;
  logic               fire;

  assign op  = shf_op_e'(in_op);
  assign cnt = in_count[CNT_W-1:0];

  shf_funnel_build u_build (
    .op(op), .wsel(in_width), .dbl(in_dbl), .cf(in_carry), .cnt(cnt),
    .a(in_opnd_a), .b(in_opnd_b),
    .funnel(funnel), .amt(amt), .left(left), .wval(wval), .wmask(wmask)
  );

  shf_stage #(.IN_W(FUN_W + 1), .OUT_W(CRS_OUT), .STEP(2 ** FINE_SEL), .SEL_W(CRS_SEL)) u_coarse (
    .din({funnel, 1'b0}), .sel(amt[CNT_W-1:FINE_SEL]), .dout(crs)
  );

  shf_stage #(.IN_W(CRS_OUT), .OUT_W(OUT_W), .STEP(1), .SEL_W(FINE_SEL)) u_fine (
    .din(crs), .sel(amt[FINE_SEL-1:0]), .dout(fine)
  );

  always_comb begin
    if (cnt == '0) begin
      res_next = in_opnd_a & wmask;
      car_next = in_carry;
    end else begin
      res_next = fine[DATA_W:1] & wmask;
      car_next = left ? fine[wval + WV_W'(1)] : fine[0];
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
    end else begin
      if (fire) begin
        out_valid  <= 1'b1;
        out_result <= res_next;
        out_carry  <= car_next;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R12
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_carry)); // R12
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_width == 2'd0 |=> out_result[31:8] == 24'd0); // R7
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_count[4:0] == 5'd0 && in_width[1] |=>
      out_result == $past(in_opnd_a) && out_carry == $past(in_carry)); // R6
  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'b000 && in_count[4:0] != 5'd0 |=> out_carry == out_result[0]); // R5
  AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'b001 && in_width[1] && in_count[4:0] != 5'd0 |=>
      out_carry == out_result[31]); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid || $past(rst_n)); // R13
endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_width = '0;
  logic        in_dbl = 1'b0;
  logic        in_carry = 1'b0;
  logic [7:0]  in_count = '0;
  logic [31:0] in_opnd_a = '0;
  logic [31:0] in_opnd_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_carry;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shf_unit uut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [1:0]  wsel;
    logic        dbl;
    logic        cf;
    logic [7:0]  cnt;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        c;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  3'b101, 2'd2, 1'b0, 1'b0, 8'd1,  32'h8000_0001, 32'h0, 32'h4000_0000, 1'b1}, // R1 SHR
    '{4'd1,  3'b100, 2'd2, 1'b0, 1'b0, 8'd1,  32'h8000_0001, 32'h0, 32'h0000_0002, 1'b1}, // R1 SHL, R5
    '{4'd2,  3'b111, 2'd2, 1'b0, 1'b0, 8'd4,  32'h8000_00F0, 32'h0, 32'hF800_000F, 1'b0}, // R2
    '{4'd2,  3'b111, 2'd0, 1'b0, 1'b0, 8'd20, 32'h0000_0080, 32'h0, 32'h0000_00FF, 1'b1}, // R2 beyond width
    '{4'd3,  3'b000, 2'd2, 1'b0, 1'b0, 8'd4,  32'h8000_0001, 32'h0, 32'h0000_0018, 1'b0}, // R3
    '{4'd3,  3'b001, 2'd1, 1'b0, 1'b0, 8'd1,  32'h0000_0001, 32'h0, 32'h0000_8000, 1'b1}, // R3 R5
    '{4'd3,  3'b000, 2'd0, 1'b0, 1'b0, 8'd9,  32'h0000_0081, 32'h0, 32'h0000_0003, 1'b1}, // R3 modulo
    '{4'd4,  3'b011, 2'd0, 1'b0, 1'b1, 8'd1,  32'h0000_000A, 32'h0, 32'h0000_0085, 1'b0}, // R4 RCR
    '{4'd4,  3'b010, 2'd0, 1'b0, 1'b0, 8'd1,  32'h0000_0080, 32'h0, 32'h0000_0000, 1'b1}, // R4 RCL
    '{4'd4,  3'b010, 2'd1, 1'b0, 1'b1, 8'd16, 32'h0000_0001, 32'h0, 32'h0000_8000, 1'b1}, // R4 full width
    '{4'd6,  3'b001, 2'd2, 1'b0, 1'b1, 8'h20, 32'h1234_5678, 32'h0, 32'h1234_5678, 1'b1}, // R6
    '{4'd6,  3'b100, 2'd0, 1'b0, 1'b0, 8'd0,  32'h0000_ABCD, 32'h0, 32'h0000_00CD, 1'b0}, // R6 R7
    '{4'd8,  3'b101, 2'd2, 1'b0, 1'b0, 8'h24, 32'h0000_0100, 32'h0, 32'h0000_0010, 1'b0}, // R8
    '{4'd7,  3'b101, 2'd0, 1'b0, 1'b0, 8'd4,  32'hFFFF_FF10, 32'h0, 32'h0000_0001, 1'b0}, // R7
    '{4'd7,  3'b000, 2'd3, 1'b0, 1'b0, 8'd8,  32'h0000_00FF, 32'h0, 32'h0000_FF00, 1'b0}, // R7 code 11
    '{4'd9,  3'b101, 2'd2, 1'b1, 1'b0, 8'd4,  32'h0000_000F, 32'h3, 32'h3000_0000, 1'b1}, // R9 right fill
    '{4'd9,  3'b100, 2'd1, 1'b1, 1'b0, 8'd2,  32'h0000_0001, 32'hC000, 32'h0000_0007, 1'b0}, // R9 left fill
    '{4'd9,  3'b000, 2'd2, 1'b1, 1'b0, 8'd1,  32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0}, // R9 ignored
    '{4'd10, 3'b110, 2'd2, 1'b1, 1'b0, 8'd2,  32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_000C, 1'b0}, // R10
    '{4'd11, 3'b101, 2'd1, 1'b0, 1'b0, 8'd17, 32'h0000_8000, 32'h0, 32'h0000_0000, 1'b0}  // R11
  };

  function automatic logic [32:0] model(input logic [2:0] op, input logic [1:0] wsel,
                                        input logic dbl, input logic cf_in, input logic [7:0] cnt,
                                        input logic [31:0] a, input logic [31:0] b);
    int w;
    int c;
    logic [31:0] m, r, y;
    logic cf, nc, sgn;
    w  = (wsel == 2'd0) ? 8 : (wsel == 2'd1) ? 16 : 32;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    c  = int'(cnt[4:0]);
    r  = a & m;
    y  = b & m;
    cf = cf_in;
    sgn = r[w-1];
    if (c == 0) return {cf, r};
    case (op)
      3'b000: begin
        for (int i = 0; i < c % w; i++) r = ((r << 1) | (r >> (w - 1))) & m;
        cf = r[0];
      end
      3'b001: begin
        for (int i = 0; i < c % w; i++) r = (r >> 1) | ((r & 32'd1) << (w - 1));
        cf = r[w-1];
      end
      3'b010: for (int i = 0; i < c; i++) begin
        nc = r[w-1]; r = ((r << 1) | 32'(cf)) & m; cf = nc;
      end
      3'b011: for (int i = 0; i < c; i++) begin
        nc = r[0]; r = (r >> 1) | (32'(cf) << (w - 1)); cf = nc;
      end
      3'b100, 3'b110: for (int i = 0; i < c; i++) begin
        cf = r[w-1];
        r  = ((r << 1) | ((dbl && op == 3'b100) ? 32'(y[w-1]) : 32'd0)) & m;
        y  = (y << 1) & m;
      end
      3'b101: for (int i = 0; i < c; i++) begin
        cf = r[0];
        r  = (r >> 1) | (dbl ? (32'(y[0]) << (w - 1)) : 32'd0);
        y  = y >> 1;
      end
      default: for (int i = 0; i < c; i++) begin
        cf = r[0]; r = (r >> 1) | (32'(sgn) << (w - 1));
      end
    endcase
    return {cf, r};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [32:0] act, input logic [32:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] op, input logic [1:0] wsel, input logic dbl,
                         input logic cf, input logic [7:0] cnt,
                         input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_op = op; in_width = wsel; in_dbl = dbl; in_carry = cf;
    in_count = cnt; in_opnd_a = a; in_opnd_b = b;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [32:0] exp;
    logic [31:0] held;
    logic [31:0] pats [3] = '{32'hA5C3_19E7, 32'h8000_0001, 32'h7FFF_FFFE};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R13 out_valid in reset", 33'(out_valid), 33'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R13 idle after reset",
        {31'd0, out_valid, in_ready}, 33'd1);

    for (int k = 0; k < NV; k++) begin
      run_one(VECS[k].op, VECS[k].wsel, VECS[k].dbl, VECS[k].cf, VECS[k].cnt, VECS[k].a, VECS[k].b);
      chk(out_valid && out_result == VECS[k].res && out_carry == VECS[k].c,
          $sformatf("vector %0d R%0d", k, VECS[k].req),
          {out_carry, out_result}, {VECS[k].c, VECS[k].res});
    end

    // Sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 against the bit-serial model
    for (int op = 0; op < 8; op++)
      for (int ws = 0; ws < 3; ws++)
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 3; p++)
            for (int c = 0; c < 32; c++) begin
              int w = (ws == 0) ? 8 : (ws == 1) ? 16 : 32;
              logic [7:0] cnt8 = {3'(c + p), 5'(c)};
              logic cfb = logic'((c + p) & 1);
              if ((op == 2 || op == 3) && c > w) continue;
              exp = model(3'(op), 2'(ws), 1'(d), cfb, cnt8, pats[p], ~pats[(p+1)%3]);
              run_one(3'(op), 2'(ws), 1'(d), cfb, cnt8, pats[p], ~pats[(p+1)%3]);
              chk({out_carry, out_result} == exp,
                  $sformatf("sweep R5 op=%0d w=%0d dbl=%0d cnt=%0d", op, w, d, c),
                  {out_carry, out_result}, exp);
            end

    // R12 back-pressure and release with a waiting request
    @(negedge clk);
    in_op = 3'b101; in_width = 2'd2; in_dbl = 1'b0; in_carry = 1'b0;
    in_count = 8'd1; in_opnd_a = 32'h10; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid && out_result == 32'h8, "R12 first result", 33'(out_result), 33'h8);
    chk(in_ready == 1'b0, "R12 in_ready low while held", 33'(in_ready), 33'd0);
    held = out_result;
    in_op = 3'b100; in_opnd_a = 32'h1; in_count = 8'd3;
    repeat (3) @(negedge clk);
    chk(out_valid && out_result == held, "R12 held stable", 33'(out_result), 33'(held));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid && out_result == 32'h8, "R12 waiting request taken on release",
        33'(out_result), 33'h8);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 drained", 33'(out_valid), 33'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule